// File: doc/BRIEF.md
# Scan-Out Fold and Parity Engine

This block copies a list of machine registers into consecutive 36-bit storage words during a logout or a scan-out. For each entry in the list it asks a source network for the register by index and receives either a 36-bit value (32 data bits plus 4 byte-parity bits) or a plain 32-bit word. A 36-bit register does not fit in one storage word next to freshly generated parity, so it is split into two words. The first word holds data bits 0-27 followed by the 4 carried parity bits. The second word, the fold word, holds data bits 28-31 in positions 24-27. A 32-bit source takes one word.

Every word written carries four generated parity bits in storage positions 32-35. Each one covers one 8-bit lane of the 32-bit payload, and that lane may itself contain carried parity bits. The first address is either a fixed logout slot (one of two fixed addresses) or, for progressive scan, the fullword after a caller-supplied instruction address. Each later word goes 4 bytes further on.

Bit numbering is most-significant-first. Storage position p is `wr_data[35-p]`. Source data bit k is `src_rsp_data[35-k]`, and source parity bit j is `src_rsp_data[3-j]`.

The request, response and write channels are valid/ready. A sender keeps valid asserted, and its payload unchanged, until the cycle in which ready is also high. At most one source request is outstanding at a time. `start`, `busy` and `done` are plain control pins.

Top module: `scanout_fold_engine`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `src_req_valid`, `src_rsp_ready` and `wr_valid` are all 0.
- R2: Source requests carry indices 0, 1, 2 … up to `reg_count`-1, in order. While `src_req_ready` is low, a pending request stays valid with an unchanged index.
- R3: For a source with `src_rsp_wide`=1, the first word written has positions 0-27 equal to data bits 0-27 and positions 28-31 equal to parity bits 0-3. That is, `wr_data[35:4]` = {`src_rsp_data[35:8]`, `src_rsp_data[3:0]`}.
- R4: For a wide source, the word that follows the first word has positions 24-27 equal to data bits 28-31 (`wr_data[11:8]` = `src_rsp_data[7:4]`). All other positions 0-31 of that word are 0.
- R5: For a source with `src_rsp_wide`=0, exactly one word is written, and its positions 0-31 equal data bits 0-31 (`wr_data[35:4]` = `src_rsp_data[35:4]`).
- R6: In every written word, storage position 32+j (`wr_data[3-j]`) is the odd parity of lane j, which is positions 8j to 8j+7. The 9 bits taken together therefore have an odd count of ones.
- R7: With `use_prog`=0, the first word goes to address 0x80 when `fixed_alt`=0 and to 0x84 when `fixed_alt`=1.
- R8: With `use_prog`=1, the first word goes to `prog_addr` rounded down to a multiple of 4, plus 4, modulo 2^AW.
- R9: Each later word of a run goes to the previous word's address plus 4, modulo 2^AW.
- R10: While `wr_ready` is low, a pending write keeps `wr_valid` high and holds `wr_addr` and `wr_data` unchanged.
- R11: `done` is high for exactly the one cycle after the last write of a run is accepted, and `busy` is low in the following cycle. With `reg_count`=0, `done` is pulsed and no write or request is issued.
- R12: A `start` pulse while `busy` is high is ignored, and so are changes to `reg_count`. The run keeps its original list length, and no extra writes follow its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the engine is idle |
| use_prog | input | 1 | 1: progressive-scan address, 0: fixed logout slot |
| fixed_alt | input | 1 | Selects the second fixed slot (0x84) |
| prog_addr | input | AW | Address of the triggering instruction |
| reg_count | input | IW+1 | Number of registers in the list |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| src_req_valid | output | 1 | Source request valid |
| src_req_ready | input | 1 | Source request accepted |
| src_req_idx | output | IW | Index of the requested register |
| src_rsp_valid | input | 1 | Source response valid |
| src_rsp_ready | output | 1 | Engine can take the response |
| src_rsp_data | input | 36 | Register value: data bits then parity bits |
| src_rsp_wide | input | 1 | 1: 36-bit register (folded), 0: 32-bit word |
| wr_valid | output | 1 | Storage write valid |
| wr_ready | input | 1 | Storage accepts the write |
| wr_addr | output | AW | Byte address of the storage word |
| wr_data | output | 36 | Payload in positions 0-31, parity in positions 32-35 |

## Verification
The hardest case to reach is a storage stall that lands between the first word and the fold word of one register, while a second `start` with a different list length arrives mid-run. Only this case shows that the fold word keeps the latched source value and that the list length cannot be changed during a run. The stimulus gets there by throttling the ready signals with a deterministic LFSR and by pulsing `start` during every run whose list is long enough. The sweep also covers progressive addresses just below the top of the address space, so that the address counter wraps.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
  localparam int DATA_W  = 32;
  localparam int PAR_W   = 4;
  localparam int WORD_W  = DATA_W + PAR_W;
  localparam int LANE_W  = 8;
  localparam int LANES   = DATA_W / LANE_W;
  localparam int HEAD_W  = DATA_W - PAR_W;   // data bits kept in the first word
  localparam int TAIL_W  = DATA_W - HEAD_W;  // data bits moved to the fold word
  localparam int TAIL_LO = 4;                // fold word: tail sits in positions 24-27

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WR_MAIN,
    ST_WR_FOLD,
    ST_FIN
  } eng_state_t;
endpackage

// File: rtl/scanout_lane_parity.sv
module scanout_lane_parity
  import scanout_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [NLANES*LANE_W-1:0] payload,
  output logic [NLANES-1:0]        par
);
  // lane j is the j-th byte from the most significant end; its parity bit
  // sits at par[NLANES-1-j] so that {payload, par} lines up positionally
  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    assign par[NLANES-1-j] = ~^payload[(NLANES-j)*LANE_W-1 -: LANE_W];
  end
endmodule

// File: rtl/scanout_formatter.sv
module scanout_formatter
  import scanout_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  logic              wide,
  input  logic              fold_phase,
  output logic [DATA_W-1:0] payload
);
  logic [HEAD_W-1:0] head;
  logic [TAIL_W-1:0] tail;
  logic [PAR_W-1:0]  carried;

  assign head    = src[WORD_W-1 -: HEAD_W];
  assign tail    = src[PAR_W +: TAIL_W];
  assign carried = src[PAR_W-1:0];

  always_comb begin
    if (!wide) begin
      payload = src[WORD_W-1:PAR_W];
    end else if (!fold_phase) begin
      payload = {head, carried};
    end else begin
      payload = '0;
      payload[TAIL_LO +: TAIL_W] = tail;
    end
  end
endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
  parameter int          AW        = 24,
  parameter logic [AW-1:0] FIXED_LO = AW'('h80)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          use_prog,
  input  logic          fixed_alt,
  input  logic [AW-1:0] prog_addr,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STRIDE   = AW'(4);
  localparam logic [AW-1:0] FIXED_HI = FIXED_LO + STRIDE;

  logic [AW-1:0] base;
  logic [AW-1:0] prog_aligned;

  assign prog_aligned = {prog_addr[AW-1:2], 2'b00};

  always_comb begin
    if (use_prog)       base = prog_aligned + STRIDE;
    else if (fixed_alt) base = FIXED_HI;
    else                base = FIXED_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= base;
    else if (step)  addr <= addr + STRIDE;
  end
endmodule

// File: rtl/scanout_fold_engine.sv
module scanout_fold_engine
  import scanout_pkg::*;
#(
  parameter int AW = 24,
  parameter int IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_prog,
  input  logic              fixed_alt,
  input  logic [AW-1:0]     prog_addr,
  input  logic [IW:0]       reg_count,
  output logic              busy,
  output logic              done,
  output logic              src_req_valid,
  input  logic              src_req_ready,
  output logic [IW-1:0]     src_req_idx,
  input  logic              src_rsp_valid,
  output logic              src_rsp_ready,
  input  logic [WORD_W-1:0] src_rsp_data,
  input  logic              src_rsp_wide,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam logic [IW:0] IDX_ONE = (IW+1)'(1);

  eng_state_t        state_q;
  logic [IW:0]       cnt_q;
  logic [IW:0]       idx_q;
  logic [WORD_W-1:0] src_q;
  logic              wide_q;
  logic              launch;
  logic              wr_fire;
  logic              last_reg;
  logic [DATA_W-1:0] payload;
  logic [LANES-1:0]  par;

  assign launch   = (state_q == ST_IDLE) && start;
  assign wr_fire  = wr_valid && wr_ready;
  assign last_reg = (idx_q + IDX_ONE) == cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      src_q   <= '0;
      wide_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          cnt_q   <= reg_count;
          idx_q   <= '0;
          state_q <= (reg_count == '0) ? ST_FIN : ST_REQ;
        end
        ST_REQ: if (src_req_ready) state_q <= ST_RSP;
        ST_RSP: if (src_rsp_valid) begin
          src_q   <= src_rsp_data;
          wide_q  <= src_rsp_wide;
          state_q <= ST_WR_MAIN;
        end
        ST_WR_MAIN: if (wr_ready) begin
          if (wide_q)        state_q <= ST_WR_FOLD;
          else if (last_reg) state_q <= ST_FIN;
          else begin
            idx_q   <= idx_q + IDX_ONE;
            state_q <= ST_REQ;
          end
        end
        ST_WR_FOLD: if (wr_ready) begin
          if (last_reg) state_q <= ST_FIN;
          else begin
            idx_q   <= idx_q + IDX_ONE;
            state_q <= ST_REQ;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = (state_q == ST_FIN);
  assign src_req_valid = (state_q == ST_REQ);
  assign src_req_idx   = idx_q[IW-1:0];
  assign src_rsp_ready = (state_q == ST_RSP);
  assign wr_valid      = (state_q == ST_WR_MAIN) || (state_q == ST_WR_FOLD);

  scanout_formatter fmt_i (
    .src        (src_q),
    .wide       (wide_q),
    .fold_phase (state_q == ST_WR_FOLD),
    .payload    (payload)
  );

  scanout_lane_parity #(.NLANES(LANES)) par_i (
    .payload (payload),
    .par     (par)
  );

  assign wr_data = {payload, par};

  scanout_addr_gen #(.AW(AW)) addr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .use_prog  (use_prog),
    .fixed_alt (fixed_alt),
    .prog_addr (prog_addr),
    .step      (wr_fire),
    .addr      (wr_addr)
  );
endmodule

// File: rtl/scanout_fold_checker.sv
module scanout_fold_checker #(
  parameter int AW = 24,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          src_req_valid,
  input logic          src_req_ready,
  input logic [IW-1:0] src_req_idx,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [35:0]   wr_data
);
  logic          have_q;
  logic [AW-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      next_q <= '0;
    end else if (done) begin
      have_q <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      have_q <= 1'b1;
      next_q <= wr_addr + AW'(4);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req_valid && !src_req_ready) |=> (src_req_valid && $stable(src_req_idx))); // R2

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R10

  AST_LANE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((^{wr_data[35:28], wr_data[3]}) && (^{wr_data[27:20], wr_data[2]}) &&
                  (^{wr_data[19:12], wr_data[1]}) && (^{wr_data[11:4],  wr_data[0]}))); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_q) |-> (wr_addr == next_q)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!src_req_valid && !wr_valid && !done)); // R1
endmodule

bind scanout_fold_engine scanout_fold_checker #(.AW(AW), .IW(IW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .src_req_valid (src_req_valid),
  .src_req_ready (src_req_ready),
  .src_req_idx   (src_req_idx),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data)
);

// File: tb/scanout_fold_engine_tb.sv
module scanout_fold_engine_tb_top;
  localparam int AW = 24;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          use_prog = 1'b0;
  logic          fixed_alt = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [IW:0]   reg_count = '0;
  logic          busy, done;
  logic          src_req_valid, src_rsp_ready, wr_valid;
  logic          src_req_ready = 1'b0;
  logic [IW-1:0] src_req_idx;
  logic          src_rsp_valid = 1'b0;
  logic [35:0]   src_rsp_data = '0;
  logic          src_rsp_wide = 1'b0;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [35:0]   wr_data;

  always #5 clk = ~clk;

  scanout_fold_engine #(.AW(AW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .use_prog(use_prog),
    .fixed_alt(fixed_alt), .prog_addr(prog_addr), .reg_count(reg_count),
    .busy(busy), .done(done),
    .src_req_valid(src_req_valid), .src_req_ready(src_req_ready), .src_req_idx(src_req_idx),
    .src_rsp_valid(src_rsp_valid), .src_rsp_ready(src_rsp_ready),
    .src_rsp_data(src_rsp_data), .src_rsp_wide(src_rsp_wide),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int fails  = 0;

  // run configuration and expectation state
  int            seed = 0;
  int            cfg_count = 0;
  bit            cfg_prog = 0;
  bit            throttle = 0;
  int            exp_total = 0;
  int            exp_idx = 0;
  int            req_idx = 0;
  bit            exp_fold = 0;
  bit            first_wr = 0;
  logic [AW-1:0] exp_addr = '0;
  int            wr_cnt = 0;
  bit            run_done = 0;
  bit            done_next = 0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] src_val(input int idx, input int s);
    logic [31:0] h;
    h = (32'(idx) * 32'h9E3779B1) ^ (32'(s) * 32'h85EBCA6B) ^ 32'h5A0F_C3A5;
    return {h, 4'(idx ^ s)};
  endfunction

  function automatic bit src_wide(input int idx, input int s);
    return ((idx + s) % 3) != 0;
  endfunction

  function automatic logic [3:0] lane_par(input logic [31:0] p);
    return {~^p[31:24], ~^p[23:16], ~^p[15:8], ~^p[7:0]};
  endfunction

  // source and storage models, all driven and sampled at the falling edge
  initial begin
    bit            rsp_fire_prev = 0;
    bit            pending = 0;
    int            pend_idx = 0;
    int            lat = 0;
    bit            stall_prev = 0;
    logic [AW-1:0] stall_addr = '0;
    logic [35:0]   stall_data = '0;
    bit            rstall_prev = 0;
    logic [IW-1:0] rstall_idx = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (done_next) begin
        chk(done == 1'b1, "R11 done after last write", 64'(done), 64'd1);
        done_next = 0;
      end
      if (done) begin
        chk(wr_cnt == exp_total, "R11 write count at done", 64'(wr_cnt), 64'(exp_total));
        chk(exp_idx == cfg_count, "R12 list length kept", 64'(exp_idx), 64'(cfg_count));
        run_done = 1;
      end
      if (stall_prev)
        chk(wr_valid && wr_addr == stall_addr && wr_data == stall_data, "R10 write held",
            {wr_valid, 3'b0, wr_addr, wr_data}, {1'b1, 3'b0, stall_addr, stall_data});
      if (rstall_prev)
        chk(src_req_valid && src_req_idx == rstall_idx, "R2 request held",
            {src_req_valid, 4'(src_req_idx)}, {1'b1, 4'(rstall_idx)});
      if (rsp_fire_prev) begin
        src_rsp_valid = 0;
        pending = 0;
      end
      if (pending && !src_rsp_valid) begin
        if (lat == 0) begin
          src_rsp_valid = 1;
          src_rsp_data  = src_val(pend_idx, seed);
          src_rsp_wide  = src_wide(pend_idx, seed);
        end else lat--;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready      = throttle ? (lfsr[0] | lfsr[3]) : 1'b1;
      src_req_ready = throttle ? (lfsr[5] | lfsr[7]) : 1'b1;

      rsp_fire_prev = src_rsp_valid && src_rsp_ready;
      stall_prev  = wr_valid && !wr_ready;
      stall_addr  = wr_addr;
      stall_data  = wr_data;
      rstall_prev = src_req_valid && !src_req_ready;
      rstall_idx  = src_req_idx;

      if (src_req_valid && src_req_ready) begin
        chk(int'(src_req_idx) == req_idx, "R2 request index", 64'(src_req_idx), 64'(req_idx));
        pending  = 1;
        pend_idx = req_idx;
        lat      = throttle ? int'(lfsr[9:8]) : 0;
        req_idx++;
      end
      if (wr_valid && wr_ready) begin
        logic [35:0] v;
        logic [31:0] sor;
        bit          w;
        string       dtag;
        string       atag;
        v = src_val(exp_idx, seed);
        w = src_wide(exp_idx, seed);
        if (!w)            begin sor = v[35:4];                       dtag = "R5 narrow word"; end
        else if (!exp_fold) begin sor = {v[35:8], v[3:0]};             dtag = "R3 first word";  end
        else               begin sor = {24'b0, v[7:4], 4'b0};          dtag = "R4 fold word";   end
        atag = first_wr ? (cfg_prog ? "R8 progressive start" : "R7 fixed start") : "R9 next address";
        chk(wr_addr == exp_addr, atag, 64'(wr_addr), 64'(exp_addr));
        chk(wr_data[35:4] == sor, dtag, 64'(wr_data[35:4]), 64'(sor));
        chk(wr_data[3:0] == lane_par(wr_data[35:4]), "R6 lane parity",
            64'(wr_data[3:0]), 64'(lane_par(wr_data[35:4])));
        first_wr = 0;
        wr_cnt++;
        exp_addr = exp_addr + AW'(4);
        if (w && !exp_fold) exp_fold = 1;
        else begin
          exp_fold = 0;
          exp_idx++;
          if (exp_idx == cfg_count) done_next = 1;
        end
      end
    end
  end

  task automatic run_case(input bit prog, input bit alt, input logic [AW-1:0] pa,
                          input int cnt, input bit thr, input int s);
    @(negedge clk);
    seed = s; cfg_count = cnt; cfg_prog = prog; throttle = thr;
    exp_total = 0;
    for (int i = 0; i < cnt; i++) exp_total += src_wide(i, s) ? 2 : 1;
    exp_idx = 0; req_idx = 0; exp_fold = 0; first_wr = 1; wr_cnt = 0; run_done = 0;
    exp_addr = prog ? ({pa[AW-1:2], 2'b00} + AW'(4)) : (alt ? AW'('h84) : AW'('h80));
    use_prog = prog; fixed_alt = alt; prog_addr = pa; reg_count = (IW+1)'(cnt);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    if (busy) begin
      // R12: a second start with a different length while busy
      reg_count = (IW+1)'(cnt + 3);
      fixed_alt = ~alt;
      prog_addr = pa + AW'(64);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int t = 0; t < 2000 && !run_done; t++) @(negedge clk);
    chk(run_done, "R11 run finished", 64'(run_done), 64'd1);
    @(negedge clk);
    chk(!busy && !done, "R11 idle after done", {busy, done}, 64'd0);
    repeat (3) begin
      @(negedge clk);
      chk(!wr_valid && !src_req_valid, "R12 no extra traffic", {wr_valid, src_req_valid}, 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, src_req_valid, src_rsp_ready, wr_valid} == 5'b0, "R1 outputs in reset",
        {busy, done, src_req_valid, src_rsp_ready, wr_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, src_req_valid, src_rsp_ready, wr_valid} == 5'b0, "R1 outputs after reset",
        {busy, done, src_req_valid, src_rsp_ready, wr_valid}, 64'd0);
    for (int thr = 0; thr < 2; thr++)
      for (int cnt = 0; cnt <= 6; cnt++)
        for (int cfg = 0; cfg < 5; cfg++) begin
          case (cfg)
            0: run_case(0, 0, AW'('h0),      cnt, thr[0], cnt * 7 + cfg + thr * 50);
            1: run_case(0, 1, AW'('h0),      cnt, thr[0], cnt * 7 + cfg + thr * 50);
            2: run_case(1, 0, AW'('h1000),   cnt, thr[0], cnt * 7 + cfg + thr * 50);
            3: run_case(1, 1, AW'('h2003),   cnt, thr[0], cnt * 7 + cfg + thr * 50);
            default: run_case(1, 0, AW'('hFFFFF6), cnt, thr[0], cnt * 7 + cfg + thr * 50);
          endcase
        end
    // full-length list
    run_case(0, 0, AW'('h0), 16, 1'b1, 999);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule